// File: doc/BRIEF.md
# Way Lookup Enable and Hit Resolution for a Set-Associative Cache

This block sits beside the tag and data arrays of a set-associative cache. It decides which ways are read on each lookup. It then merges the per-way tag-compare results into one hit, the index of the hit way, and an error flag for a lookup that matches in more than one way.

Each access type (instruction or data) has a mask of ways that are barred from allocation on a miss. A mode bit lets those same masks also bar ways from lookup. With the mode set, instruction lookups and data lookups can be steered to separate groups of ways, and a barred way's arrays are not read, which saves power. Per-line maintenance follows the same gating as a normal access of its type. Whole-cache invalidate and flush always reach every way, whatever the mode is.

The block is purely combinational. The way count is a parameter with a default of 4.

Top module: `wg_way_gate`

## Requirements
- R1: When `gate_mode` is 0 and `op_class` is 2'b00 (normal access) or 2'b01 (per-line maintenance), `lookup_en` is all ones, whatever the two masks hold.
- R2: When `gate_mode` is 1, `op_class` is 2'b00 and `acc_is_data` is 0 (instruction), `lookup_en` equals the bitwise inverse of `instr_dis`, and `data_dis` has no effect. When every way is disabled, `lookup_en` is all zeros.
- R3: When `gate_mode` is 1, `op_class` is 2'b00 and `acc_is_data` is 1 (data), `lookup_en` equals the bitwise inverse of `data_dis`, and `instr_dis` has no effect.
- R4: Per-line maintenance (`op_class` 2'b01) with `gate_mode` set to 1 is gated exactly as a normal access of the same `acc_is_data` type, so ways disabled for that type are left untouched.
- R5: Whole-cache invalidate or flush (`op_class` 2'b10) makes `lookup_en` all ones, whatever `gate_mode` and the masks hold.
- R6: The reserved code `op_class` 2'b11 is treated as a normal access (2'b00).
- R7: `hit` is 1 exactly when some way has both `way_hit_raw` and `lookup_en` set. A raw hit in a way that is not enabled is ignored.
- R8: `hit_way` gives the lowest-numbered way whose raw hit is enabled. It is 0 when `hit` is 0.
- R9: `multi_hit` is 1 exactly when two or more enabled ways report a raw hit. `hit` stays 1 in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_is_data | input | 1 | Access type: 0 instruction, 1 data |
| op_class | input | 2 | 00 normal, 01 per-line maintenance, 10 whole-cache invalidate/flush, 11 treated as 00 |
| gate_mode | input | 1 | 1 applies the allocation-disable masks to lookup as well |
| instr_dis | input | NUM_WAYS | Ways disabled for instruction allocation |
| data_dis | input | NUM_WAYS | Ways disabled for data allocation |
| way_hit_raw | input | NUM_WAYS | Tag-compare match for each way |
| lookup_en | output | NUM_WAYS | Read enable for each way's tag and data arrays |
| hit | output | 1 | At least one enabled way matched |
| hit_way | output | $clog2(NUM_WAYS) | Index of the lowest enabled matching way |
| multi_hit | output | 1 | Two or more enabled ways matched |

## Verification
The hardest case to bring about is a raw match in a way that gating has masked off, sitting next to a real hit in an enabled way. In that case the result must ignore the masked way, both in the hit index and in the multiple-hit flag. The vector table sets up that overlap on purpose: the masks and the raw hit pattern are chosen so that a masked match sits below the enabled one and would win the priority if gating were lost. Other vectors repeat the same pattern under per-line maintenance, whole-cache operations and the reserved code, which checks that each operation class picks the right mask.

// File: rtl/wg_pkg.sv
package wg_pkg;

   typedef enum logic [1:0] {
      OP_ACCESS = 2'b00,
      OP_LINE   = 2'b01,
      OP_WHOLE  = 2'b10,
      OP_RSVD   = 2'b11
   } wg_op_e;

endpackage

// File: rtl/wg_lookup_mask.sv
module wg_lookup_mask #(
   parameter int NUM_WAYS = 4
) (
   input  logic                gate_mode,
   input  logic                acc_is_data,
   input  logic [1:0]          op_class,
   input  logic [NUM_WAYS-1:0] instr_dis,
   input  logic [NUM_WAYS-1:0] data_dis,
   output logic [NUM_WAYS-1:0] lookup_en
);
   import wg_pkg::*;

   wg_op_e op_q;
   logic   all_ways;

   // Whole-cache operations bypass the mode; the reserved code is a normal access.
   always_comb begin
      op_q     = wg_op_e'(op_class);
      all_ways = (op_q == OP_WHOLE) || !gate_mode;
   end

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic barred;
      assign barred       = acc_is_data ? data_dis[w] : instr_dis[w];
      assign lookup_en[w] = all_ways || !barred;
   end

endmodule

// File: rtl/wg_hit_gate.sv
module wg_hit_gate #(
   parameter int NUM_WAYS = 4
) (
   input  logic [NUM_WAYS-1:0] lookup_en,
   input  logic [NUM_WAYS-1:0] way_hit_raw,
   output logic [NUM_WAYS-1:0] gated_hit
);
   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      assign gated_hit[w] = way_hit_raw[w] & lookup_en[w];
   end
endmodule

// File: rtl/wg_way_encoder.sv
module wg_way_encoder #(
   parameter int NUM_WAYS  = 4,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IDX_W    = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0] vec,
   output logic                any,
   output logic [IDX_W-1:0]    idx
);
   if (LOW_FIRST) begin : g_low
      always_comb begin
         idx = '0;
         for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (vec[w]) idx = IDX_W'(w);
         end
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int w = 0; w < NUM_WAYS; w++) begin
            if (vec[w]) idx = IDX_W'(w);
         end
      end
   end

   assign any = |vec;
endmodule

// File: rtl/wg_multi_detect.sv
module wg_multi_detect #(
   parameter int NUM_WAYS = 4
) (
   input  logic [NUM_WAYS-1:0] vec,
   output logic                multi
);
   always_comb begin
      logic seen;
      seen  = 1'b0;
      multi = 1'b0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (vec[w]) begin
            if (seen) multi = 1'b1;
            seen = 1'b1;
         end
      end
   end
endmodule

// File: rtl/wg_way_gate.sv
module wg_way_gate #(
   parameter int NUM_WAYS  = 4,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IDX_W    = $clog2(NUM_WAYS)
) (
   input  logic                acc_is_data,
   input  logic [1:0]          op_class,
   input  logic                gate_mode,
   input  logic [NUM_WAYS-1:0] instr_dis,
   input  logic [NUM_WAYS-1:0] data_dis,
   input  logic [NUM_WAYS-1:0] way_hit_raw,
   output logic [NUM_WAYS-1:0] lookup_en,
   output logic                hit,
   output logic [IDX_W-1:0]    hit_way,
   output logic                multi_hit
);
   if (NUM_WAYS < 2) begin : g_bad_low
      $error("wg_way_gate: NUM_WAYS must be at least 2");
   end
   if (NUM_WAYS > 64) begin : g_bad_high
      $error("wg_way_gate: NUM_WAYS must not exceed 64");
   end

   logic [NUM_WAYS-1:0] gated_hit;

   wg_lookup_mask #(.NUM_WAYS(NUM_WAYS)) mask_i (
      .gate_mode   (gate_mode),
      .acc_is_data (acc_is_data),
      .op_class    (op_class),
      .instr_dis   (instr_dis),
      .data_dis    (data_dis),
      .lookup_en   (lookup_en)
   );

   wg_hit_gate #(.NUM_WAYS(NUM_WAYS)) gate_i (
      .lookup_en   (lookup_en),
      .way_hit_raw (way_hit_raw),
      .gated_hit   (gated_hit)
   );

   wg_way_encoder #(.NUM_WAYS(NUM_WAYS), .LOW_FIRST(LOW_FIRST)) enc_i (
      .vec (gated_hit),
      .any (hit),
      .idx (hit_way)
   );

   wg_multi_detect #(.NUM_WAYS(NUM_WAYS)) multi_i (
      .vec   (gated_hit),
      .multi (multi_hit)
   );
endmodule

// File: rtl/wg_way_gate_chk.sv
module wg_way_gate_chk #(
   parameter int NUM_WAYS = 4,
   localparam int IDX_W   = $clog2(NUM_WAYS)
) (
   input logic                acc_is_data,
   input logic [1:0]          op_class,
   input logic                gate_mode,
   input logic [NUM_WAYS-1:0] instr_dis,
   input logic [NUM_WAYS-1:0] data_dis,
   input logic [NUM_WAYS-1:0] way_hit_raw,
   input logic [NUM_WAYS-1:0] lookup_en,
   input logic                hit,
   input logic [IDX_W-1:0]    hit_way,
   input logic                multi_hit
);
   logic                is_whole;
   logic [NUM_WAYS-1:0] type_mask;
   logic [NUM_WAYS-1:0] matched;
   logic [NUM_WAYS-1:0] below;

   always_comb begin
      is_whole  = (op_class == 2'b10);
      type_mask = acc_is_data ? data_dis : instr_dis;
      matched   = way_hit_raw & lookup_en;
      below     = matched & ((NUM_WAYS'(1) << hit_way) - NUM_WAYS'(1));

      // R1
      mode_off_all_chk: assert (gate_mode || is_whole || (&lookup_en));
      // R2
      mode_on_gate_chk: assert (!gate_mode || is_whole || (lookup_en == ~type_mask));
      // R5
      whole_all_chk: assert (!is_whole || (&lookup_en));
      // R7
      hit_match_chk: assert (hit == (|matched));
      // R8
      hit_way_valid_chk: assert (!hit || (way_hit_raw[hit_way] && lookup_en[hit_way]));
      // R8
      hit_way_lowest_chk: assert (below == '0);
      // R9
      multi_needs_hit_chk: assert (!multi_hit || hit);
      // R9
      multi_count_chk: assert (multi_hit == ($countones(matched) > 1));
   end
endmodule

bind wg_way_gate wg_way_gate_chk #(.NUM_WAYS(NUM_WAYS)) chk_i (
   .acc_is_data (acc_is_data),
   .op_class    (op_class),
   .gate_mode   (gate_mode),
   .instr_dis   (instr_dis),
   .data_dis    (data_dis),
   .way_hit_raw (way_hit_raw),
   .lookup_en   (lookup_en),
   .hit         (hit),
   .hit_way     (hit_way),
   .multi_hit   (multi_hit)
);

// File: tb/wg_way_gate_tb_top.sv
module wg_way_gate_tb_top;
   localparam int NW   = 4;
   localparam int NVEC = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          acc_is_data, gate_mode;
   logic [1:0]    op_class;
   logic [NW-1:0] instr_dis, data_dis, way_hit_raw, lookup_en;
   logic          hit, multi_hit;
   logic [1:0]    hit_way;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   wg_way_gate #(.NUM_WAYS(NW)) dut_i (
      .acc_is_data (acc_is_data),
      .op_class    (op_class),
      .gate_mode   (gate_mode),
      .instr_dis   (instr_dis),
      .data_dis    (data_dis),
      .way_hit_raw (way_hit_raw),
      .lookup_en   (lookup_en),
      .hit         (hit),
      .hit_way     (hit_way),
      .multi_hit   (multi_hit)
   );

   // Layout: mode, data, op[2], imask[4], dmask[4], raw[4], en[4], hit, way[2], multi, req[4]
   localparam logic [27:0] VEC [NVEC] = '{
      {1'b0,1'b0,2'd0,4'hF,4'h0,4'h2, 4'hF,1'b1,2'd1,1'b0, 4'd1}, // R1
      {1'b0,1'b1,2'd1,4'h0,4'hF,4'h8, 4'hF,1'b1,2'd3,1'b0, 4'd1}, // R1
      {1'b1,1'b0,2'd0,4'h3,4'hC,4'h3, 4'hC,1'b0,2'd0,1'b0, 4'd2}, // R2
      {1'b1,1'b0,2'd0,4'h3,4'hC,4'h5, 4'hC,1'b1,2'd2,1'b0, 4'd2}, // R2
      {1'b1,1'b1,2'd0,4'h3,4'hC,4'h5, 4'h3,1'b1,2'd0,1'b0, 4'd3}, // R3
      {1'b1,1'b1,2'd0,4'hF,4'h5,4'hB, 4'hA,1'b1,2'd1,1'b1, 4'd3}, // R3
      {1'b1,1'b0,2'd1,4'h6,4'h0,4'h6, 4'h9,1'b0,2'd0,1'b0, 4'd4}, // R4
      {1'b1,1'b1,2'd1,4'h0,4'h8,4'h8, 4'h7,1'b0,2'd0,1'b0, 4'd4}, // R4
      {1'b1,1'b0,2'd2,4'hF,4'hF,4'h8, 4'hF,1'b1,2'd3,1'b0, 4'd5}, // R5
      {1'b0,1'b1,2'd2,4'h0,4'hF,4'h0, 4'hF,1'b0,2'd0,1'b0, 4'd5}, // R5
      {1'b1,1'b1,2'd3,4'h0,4'h1,4'h1, 4'hE,1'b0,2'd0,1'b0, 4'd6}, // R6
      {1'b0,1'b0,2'd0,4'h0,4'h0,4'hF, 4'hF,1'b1,2'd0,1'b1, 4'd9}, // R9
      {1'b1,1'b0,2'd0,4'h1,4'h0,4'h7, 4'hE,1'b1,2'd1,1'b1, 4'd7}  // R7 masked way 0 below hits
   };

   task automatic drive(input logic m, input logic d, input logic [1:0] op,
                        input logic [3:0] im, input logic [3:0] dm, input logic [3:0] raw);
      @(negedge clk);
      gate_mode = m; acc_is_data = d; op_class = op;
      instr_dis = im; data_dis = dm; way_hit_raw = raw;
      #1;
   endtask

   task automatic expect_all(input int req, input logic [3:0] en, input logic h,
                             input logic [1:0] w, input logic mh);
      checks++;
      if (lookup_en !== en || hit !== h || hit_way !== w || multi_hit !== mh) begin
         failures++;
         $display("FAIL R%0d: got en=%h hit=%b way=%0d multi=%b, expected en=%h hit=%b way=%0d multi=%b",
                  req, lookup_en, hit, hit_way, multi_hit, en, h, w, mh);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      gate_mode = 1'b0; acc_is_data = 1'b0; op_class = 2'b00;
      instr_dis = '0; data_dis = '0; way_hit_raw = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1 R7: quiet state under reset
      expect_all(1, 4'hF, 1'b0, 2'd0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         logic [27:0] v;
         v = VEC[i];
         drive(v[27], v[26], v[25:24], v[23:20], v[19:16], v[15:12]);
         expect_all(int'(v[3:0]), v[11:8], v[7], v[6:5], v[4]);
      end

      // R8: single hit walked across every way
      for (int w = 0; w < NW; w++) begin
         drive(1'b0, 1'b1, 2'b00, 4'h0, 4'h0, 4'(1 << w));
         expect_all(8, 4'hF, 1'b1, 2'(w), 1'b0);
      end

      // R2: every way barred for instruction lookup
      drive(1'b1, 1'b0, 2'b00, 4'hF, 4'h0, 4'hF);
      expect_all(2, 4'h0, 1'b0, 2'd0, 1'b0);

      // R3: instruction mask does not touch data lookup
      drive(1'b1, 1'b1, 2'b00, 4'hF, 4'h0, 4'hC);
      expect_all(3, 4'hF, 1'b1, 2'd2, 1'b1);

      // R5: whole-cache with both masks full still reaches all ways
      drive(1'b1, 1'b1, 2'b10, 4'hF, 4'hF, 4'h6);
      expect_all(5, 4'hF, 1'b1, 2'd1, 1'b1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule